// File: doc/BRIEF.md
# Time-of-Day Alarm Match Unit

This unit holds four alarm bytes (seconds, minutes, hours and day of month, all in BCD) and compares them with the current time of day that a separate clock core supplies. The comparison runs only in the cycle that carries the once-per-second tick. When the comparison hits, the unit sends a single-cycle interrupt pulse in the next cycle.

The top bit of each alarm byte is a mask bit. The set of mask bits that are set picks how often the alarm repeats. Clearing every mask gives a once-a-month alarm. Setting masks from the date field downward in a nested way gives a daily, hourly or per-minute alarm. Any other mix of masks makes the alarm fire on every tick.

Software loads the alarm bytes through a byte-wide write port with a two-bit field select. A value that is out of range for its field is dropped, and the stored byte keeps its old value.

Top module: `rtc_alarm_match`

## Requirements
- R1: Field select encoding: 0 = seconds, 1 = minutes, 2 = hours, 3 = date. An accepted write stores all 8 bits of the data into the selected alarm byte. Bit 7 of each stored byte is that field's mask bit.
- R2: When all four mask bits are clear, an event occurs on a tick only if seconds, minutes, hours and date all match.
- R3: Three mask patterns give nested repeat rates. Date mask alone: seconds, minutes and hours must match (daily). Date and hours masks: seconds and minutes must match (hourly). Date, hours and minutes masks: only seconds must match (per minute).
- R4: Every other mask pattern gives an event on every tick. This includes any pattern with the seconds mask set, and any non-nested pattern such as the hours mask alone.
- R5: A write is dropped with no effect in these cases. Seconds or minutes: the value (bits 6:4 as tens, bits 3:0 as units) is above 59. Hours: the value (bits 5:4 as tens, bits 3:0 as units) is above 23. Date: bits 5:0 are all zero.
- R6: Seconds and minutes are compared on bits 6:0. Hours and date are compared on bits 5:0. Higher bits of both the alarm byte and the current-time byte play no part in the comparison.
- R7: `irq` is low out of reset. An event drives `irq` high for exactly one clock, in the cycle after the tick.
- R8: No event is produced in a cycle without `tick_1hz`, even if the time matches.
- R9: A write in the same cycle as a tick does not affect that tick's comparison. The new value applies from the next tick on, and no event from the old setting is held over.
- R10: `irq_en` low suppresses the pulse. The comparison keeps running, so a later match with `irq_en` high pulses normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| irq_en | input | 1 | Interrupt enable, active high |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| wr_en | input | 1 | Alarm byte write strobe |
| wr_sel | input | 2 | Alarm field select |
| wr_data | input | 8 | Alarm byte write data |
| irq | output | 1 | Alarm interrupt pulse |

## Verification
The bench walks through each legal repeat rate and, for each one, checks both a hit and a near miss. It also checks a non-nested mask pattern; a decoder that reads masks one at a time would give a partial match there instead of firing on every tick.

Out-of-range writes are tested at each field's limit, including a masked date of zero. A design that accepts any of them would lose the old alarm, so the next matching tick would stay silent.

A further check sets stray upper bits on both the stored hour and the incoming time. A design that compared too many bits would then miss a match. A write in the same cycle as a tick would show up as an early pulse in a design that compares against the next register value. A design that gates the comparison, rather than the pulse, with the enable is caught by the pulse that follows re-enabling.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
    localparam int BYTE_W   = 8;
    localparam int N_FLD    = 4;
    localparam int SEL_W    = $clog2(N_FLD);
    localparam int MASK_BIT = BYTE_W - 1;

    typedef logic [BYTE_W-1:0] bcd_t;
    typedef logic [N_FLD-1:0][BYTE_W-1:0] fld_vec_t;

    typedef enum logic [2:0] {
        RATE_MONTH,
        RATE_DAY,
        RATE_HOUR,
        RATE_MIN,
        RATE_SEC
    } rate_e;

    // field index: 0 seconds, 1 minutes, 2 hours, 3 date
    function automatic int unsigned fld_width(int unsigned f);
        return (f < 2) ? 7 : 6;
    endfunction

    function automatic int unsigned bcd_dec(bcd_t v, int unsigned w);
        bcd_t m;
        m = v & bcd_t'((1 << w) - 1);
        return int'(m[7:4]) * 10 + int'(m[3:0]);
    endfunction

    function automatic logic fld_ok(int unsigned f, bcd_t v);
        case (f)
            0, 1:    return bcd_dec(v, 7) <= 59;
            2:       return bcd_dec(v, 6) <= 23;
            default: return v[5:0] != 6'd0;
        endcase
    endfunction
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  bcd_t             wr_data,
    output fld_vec_t         alm_o
);
    typedef struct packed {
        fld_vec_t alm;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int f = 0; f < N_FLD; f++) begin
            if (wr_en && (wr_sel == SEL_W'(f)) && fld_ok(f, wr_data)) begin
                st_d.alm[f] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alm_o = st_q.alm;
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_alarm_pkg::*;
(
    input  fld_vec_t alm_i,
    input  fld_vec_t cur_i,
    output rate_e    rate_o,
    output logic     match_o
);
    logic [N_FLD-1:0] eq;
    logic [N_FLD-1:0] msk;

    for (genvar g = 0; g < N_FLD; g++) begin : g_fld
        localparam int W = fld_width(g);
        assign eq[g]  = (alm_i[g][W-1:0] == cur_i[g][W-1:0]);
        assign msk[g] = alm_i[g][MASK_BIT];
    end

    always_comb begin
        case (msk)
            4'b0000: rate_o = RATE_MONTH;
            4'b1000: rate_o = RATE_DAY;
            4'b1100: rate_o = RATE_HOUR;
            4'b1110: rate_o = RATE_MIN;
            default: rate_o = RATE_SEC;
        endcase
    end

    always_comb begin
        case (rate_o)
            RATE_MONTH: match_o = &eq;
            RATE_DAY:   match_o = &eq[2:0];
            RATE_HOUR:  match_o = &eq[1:0];
            RATE_MIN:   match_o = eq[0];
            default:    match_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1hz,
    input  logic       irq_en,
    input  logic [7:0] cur_sec,
    input  logic [7:0] cur_min,
    input  logic [7:0] cur_hour,
    input  logic [7:0] cur_date,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic       irq
);
    typedef struct packed {
        logic irq;
    } out_t;

    fld_vec_t alm_regs;
    fld_vec_t cur_pack;
    rate_e    rate;
    logic     hit;
    out_t     st_d, st_q;

    assign cur_pack = {cur_date, cur_hour, cur_min, cur_sec};

    rtc_alarm_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wr_data(wr_data),
        .alm_o  (alm_regs)
    );

    rtc_alarm_cmp u_cmp (
        .alm_i  (alm_regs),
        .cur_i  (cur_pack),
        .rate_o (rate),
        .match_o(hit)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = tick_1hz && hit && irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;
endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk
    import rtc_alarm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tick_1hz,
    input logic       irq_en,
    input logic       wr_en,
    input logic [1:0] wr_sel,
    input logic [7:0] wr_data,
    input logic       irq,
    input fld_vec_t   alm_regs
);
    logic [6:0] wr_sec_val;
    assign wr_sec_val = 7'(wr_data[6:4]) * 7'd10 + 7'(wr_data[3:0]);

    p_date_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3 && wr_data[5:0] != 6'd0) |=> alm_regs[3] == $past(wr_data));

    p_any_sec_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && irq_en && alm_regs[0][7]) |=> irq);

    p_bad_sec_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0 && wr_sec_val > 7'd59) |=> $stable(alm_regs[0]));

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !tick_1hz) |=> !irq);

    p_tick_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(tick_1hz));

    p_enable_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(irq_en));
endmodule

bind rtc_alarm_match rtc_alarm_match_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_1hz(tick_1hz),
    .irq_en  (irq_en),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .irq     (irq),
    .alm_regs(alm_regs)
);

// File: tb/rtc_alarm_match_tb_top.sv
module rtc_alarm_match_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       irq_en = 1'b0;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    logic  exp_q[$];
    string tag_q[$];
    logic [7:0] sh [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_alarm_match dut_i (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .irq_en(irq_en),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .irq(irq)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: irq=%0b expected %0b", tag, act, exp);
        end
    endtask

    function automatic logic val_ok(input int sel, input logic [7:0] d);
        int t;
        case (sel)
            0, 1: begin t = d[6:4] * 10 + d[3:0]; return t <= 59; end
            2:    begin t = d[5:4] * 10 + d[3:0]; return t <= 23; end
            default: return d[5:0] != 0;
        endcase
    endfunction

    function automatic logic model(input logic [7:0] s, m, h, d);
        logic es, em, eh, ed;
        logic [3:0] k;
        es = sh[0][6:0] == s[6:0];
        em = sh[1][6:0] == m[6:0];
        eh = sh[2][5:0] == h[5:0];
        ed = sh[3][5:0] == d[5:0];
        k  = {sh[3][7], sh[2][7], sh[1][7], sh[0][7]};
        if (k == 4'b0000) return es & em & eh & ed;
        if (k == 4'b1000) return es & em & eh;
        if (k == 4'b1100) return es & em;
        if (k == 4'b1110) return es;
        return 1'b1;
    endfunction

    task automatic wr(input int sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_data = d;
        if (val_ok(sel, d)) sh[sel] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: pushes the expected pulse, then raises the tick
    task automatic tick_at(input logic [7:0] s, m, h, d, input string tag,
                           input logic do_wr = 1'b0, input int sel = 0,
                           input logic [7:0] wd = 8'h00);
        @(negedge clk);
        cur_sec = s; cur_min = m; cur_hour = h; cur_date = d;
        exp_q.push_back(irq_en & model(s, m, h, d));
        tag_q.push_back(tag);
        tick_1hz = 1'b1;
        if (do_wr) begin
            wr_en = 1'b1; wr_sel = 2'(sel); wr_data = wd;
            if (val_ok(sel, wd)) sh[sel] = wd;
        end
        @(negedge clk);
        tick_1hz = 1'b0; wr_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // monitor: pops an expectation for every tick and checks the pulse width
    initial begin
        forever begin
            @(posedge clk);
            if (tick_1hz) begin
                logic  e;
                string t;
                @(negedge clk);
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(irq, e, t);
                @(negedge clk);
                chk(irq, 1'b0, {t, " R7 pulse ends"});
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog: irq=%0b expected run to end", irq);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) sh[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(irq, 1'b0, "R7 reset state");
        rst_n = 1'b1;
        irq_en = 1'b1;
        @(negedge clk);

        wr(0, 8'h56); wr(1, 8'h34); wr(2, 8'h12); wr(3, 8'h15);
        tick_at(8'h56, 8'h34, 8'h12, 8'h15, "R1/R2 monthly hit");
        tick_at(8'h56, 8'h34, 8'h12, 8'h16, "R2 date miss");
        tick_at(8'h57, 8'h34, 8'h12, 8'h15, "R2 seconds miss");

        wr(3, 8'h95);
        tick_at(8'h56, 8'h34, 8'h12, 8'h20, "R3 daily hit");
        tick_at(8'h56, 8'h35, 8'h12, 8'h20, "R3 daily minute miss");
        wr(2, 8'h92);
        tick_at(8'h56, 8'h34, 8'h07, 8'h01, "R3 hourly hit");
        tick_at(8'h56, 8'h33, 8'h07, 8'h01, "R3 hourly minute miss");
        wr(1, 8'hB4);
        tick_at(8'h56, 8'h00, 8'h00, 8'h01, "R3 per-minute hit");
        tick_at(8'h55, 8'h00, 8'h00, 8'h01, "R3 per-minute seconds miss");

        wr(0, 8'hD6);
        tick_at(8'h01, 8'h02, 8'h03, 8'h04, "R4 all masks");
        wr(0, 8'h56); wr(1, 8'h34); wr(3, 8'h15);
        tick_at(8'h00, 8'h00, 8'h00, 8'h01, "R4 hours mask alone");
        wr(2, 8'h12);
        tick_at(8'h56, 8'h34, 8'h12, 8'h15, "R1 monthly restored");

        wr(0, 8'h60); wr(1, 8'h5A); wr(2, 8'h24); wr(3, 8'h00); wr(3, 8'h80);
        tick_at(8'h56, 8'h34, 8'h12, 8'h15, "R5 old alarm kept");
        tick_at(8'h60, 8'h34, 8'h12, 8'h15, "R5 rejected seconds");

        wr(2, 8'h52);
        tick_at(8'hD6, 8'hB4, 8'h12, 8'h55, "R6 upper bits ignored");

        @(negedge clk);
        cur_sec = 8'h56; cur_min = 8'h34; cur_hour = 8'h12; cur_date = 8'h15;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(irq, 1'b0, "R8 no tick no pulse");
        end

        irq_en = 1'b0;
        tick_at(8'h56, 8'h34, 8'h12, 8'h15, "R10 disabled");
        irq_en = 1'b1;
        tick_at(8'h56, 8'h34, 8'h12, 8'h15, "R10 re-enabled");

        tick_at(8'h10, 8'h34, 8'h12, 8'h15, "R9 same-cycle write", 1'b1, 0, 8'h10);
        tick_at(8'h10, 8'h34, 8'h12, 8'h15, "R9 next tick");

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule